// File: doc/BRIEF.md
# Two-Step Time-Code Symbol Receiver

This block recovers four small binary codes per symbol from a serial line that the receiver samples once per clock tick. Each symbol on the line is a pair of pulses: a fixed-position reference pulse, then a data pulse whose leading and trailing edges are each shifted in time by the transmitter. A toggling path selector sends successive pulses alternately to the reference path and the data path. The reference leading edge is the time origin for both measurements.

Two intervals are timed in ticks: reference rise to data rise, and reference rise to data fall. Each interval first has a fixed static offset removed. It is then decoded in two steps. A coarse converter compares it against taps spaced K ticks apart and picks the last tap passed, which gives the A code (rise) or the C code (fall). A fine converter measures the remainder from that chosen tap, which gives the B or D code. Small converters replace one wide converter. A result strobe comes out a fixed number of cycles after each reference edge. If a data edge does not arrive in time, an error strobe is raised in place of the result strobe.

Top module: `tcode_rx`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o` and `err_o` are low and `a_o`, `b_o`, `c_o`, `d_o` are all zero, until the first symbol completes.
- R2: The line is sampled once per tick, and a rising edge is a tick at 1 after a tick at 0. When no symbol is open, the first rising edge is taken as the reference pulse. The next rising edge is taken as the data pulse.
- R3: Both intervals are counted in whole ticks from the tick of the reference rising edge. One ends at the tick where the data pulse first reads 1; the other ends at the first tick where it reads 0 again.
- R4: The coarse codes are A = min(floor((tr - RISE_OFS)/K), 2^CW-1) and C = min(floor((tf - FALL_OFS)/K), 2^CW-1), where tr and tf are the rise and fall intervals. A code is 0 when its interval is below its offset. A fine shift smaller than K leaves the coarse code unchanged.
- R5: The fine codes are B = min(tr - RISE_OFS - A*K, 2^FW-1) and D = min(tf - FALL_OFS - C*K, 2^FW-1), each 0 when its interval is below its offset. The fine code is therefore measured from the coarse tap that was selected.
- R6: For a complete symbol, `valid_o` is high for exactly one cycle, WINDOW+1 cycles after the tick of the reference rising edge, and the four codes are presented in that same cycle. The codes change only when `valid_o` is high.
- R7: If either data edge has not arrived before the interval count reaches WINDOW, `err_o` pulses in the cycle where `valid_o` would have pulsed. In that case `valid_o` stays low and the codes keep their previous values.
- R8: When a symbol window closes, the path selector returns to expecting a reference pulse, even if the data pulse was missing.
- R9: A reference rising edge that arrives in the cycle where the previous window closes starts a new symbol. The previous symbol's result is still delivered on schedule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_i | input | 1 | Sampled serial line carrying reference and data pulses |
| valid_o | output | 1 | One-cycle strobe: a symbol was recovered |
| err_o | output | 1 | One-cycle strobe: a data edge was missing in the window |
| a_o | output | CW | Coarse code of the rising-edge interval |
| b_o | output | FW | Fine code of the rising-edge interval |
| c_o | output | CW | Coarse code of the falling-edge interval |
| d_o | output | FW | Fine code of the falling-edge interval |

## Verification
Two events can fall in the same cycle: the close of one symbol window, which emits its result, and the reference edge of the next symbol, which starts a new count. The bench causes this by making symbols exactly WINDOW ticks long, so the next reference pulse rises in the closing tick. It then checks that both symbols come out with correct codes, each exactly WINDOW+1 cycles after its own reference edge. A symbol with no data pulse, placed just before such a tight pair, also checks that the path selector re-aligns when the window closes.

// File: rtl/tcode_rx_pkg.sv
package tcode_rx_pkg;

  // Which stream the next rising edge on the line belongs to.
  typedef enum logic {
    PH_REF  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

  // Width used for interval arithmetic inside the converters.
  localparam int unsigned XW = 32;

endpackage

// File: rtl/tcr_split.sv
module tcr_split
  import tcode_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic resync_i,
  output logic ref_rise_o,
  output logic dat_rise_o,
  output logic dat_fall_o
);

  logic   line_q;
  phase_e phase_q, phase_d;
  logic   rise, fall;

  always_comb begin
    rise = line_i & ~line_q;
    fall = ~line_i & line_q;
    // At a window close any rising edge is forced onto the reference path.
    ref_rise_o = rise & ((phase_q == PH_REF) | resync_i);
    dat_rise_o = rise & (phase_q == PH_DATA) & ~resync_i;
    // After a data rise the selector flips back, so a data fall sees PH_REF.
    dat_fall_o = fall & (phase_q == PH_REF);
  end

  always_comb begin
    phase_d = phase_q;
    if (ref_rise_o)      phase_d = PH_DATA;
    else if (dat_rise_o) phase_d = PH_REF;
    else if (resync_i)   phase_d = PH_REF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      phase_q <= PH_REF;
    end else begin
      line_q  <= line_i;
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/tcr_timer.sv
module tcr_timer #(
  parameter int WINDOW = 40,
  localparam int CNT_W = $clog2(WINDOW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_rise_i,
  input  logic             dat_rise_i,
  input  logic             dat_fall_i,
  output logic             close_o,
  output logic             good_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rise_t_o,
  output logic [CNT_W-1:0] fall_t_o
);

  localparam logic [CNT_W-1:0] WIN_L = CNT_W'(WINDOW);
  localparam logic [CNT_W-1:0] ONE_L = CNT_W'(1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             got_r_q, got_r_d, got_f_q, got_f_d;
  logic [CNT_W-1:0] rt_q, rt_d, ft_q, ft_d;
  logic             start, live, take_r, take_f, en;

  always_comb begin
    close_o = busy_q && (cnt_q == WIN_L);
    start   = ref_rise_i && (!busy_q || close_o);
    live    = busy_q && !close_o;
    take_r  = live && dat_rise_i && !got_r_q;
    take_f  = live && dat_fall_i && got_r_q && !got_f_q;
    en      = start | busy_q;

    busy_d  = busy_q;
    cnt_d   = cnt_q;
    got_r_d = got_r_q;
    got_f_d = got_f_q;
    rt_d    = rt_q;
    ft_d    = ft_q;

    if (start) begin
      busy_d  = 1'b1;
      cnt_d   = ONE_L;
      got_r_d = 1'b0;
      got_f_d = 1'b0;
    end else begin
      if (close_o) busy_d = 1'b0;
      if (live)    cnt_d  = cnt_q + ONE_L;
      if (take_r) begin
        got_r_d = 1'b1;
        rt_d    = cnt_q;
      end
      if (take_f) begin
        got_f_d = 1'b1;
        ft_d    = cnt_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      got_r_q <= 1'b0;
      got_f_q <= 1'b0;
      rt_q    <= '0;
      ft_q    <= '0;
    end else if (en) begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      got_r_q <= got_r_d;
      got_f_q <= got_f_d;
      rt_q    <= rt_d;
      ft_q    <= ft_d;
    end
  end

  assign good_o   = got_r_q && got_f_q;
  assign busy_o   = busy_q;
  assign cnt_o    = cnt_q;
  assign rise_t_o = rt_q;
  assign fall_t_o = ft_q;

endmodule

// File: rtl/tcr_coarse.sv
module tcr_coarse
  import tcode_rx_pkg::*;
#(
  parameter int CW  = 2,
  parameter int K   = 4,
  parameter int OFS = 4
) (
  input  logic [XW-1:0] t_i,
  output logic [CW-1:0] code_o,
  output logic [XW-1:0] origin_o,
  output logic          below_o
);

  localparam int NT = 1 << CW;

  logic [NT-1:0] hit;

  // One comparator per tap; tap i sits at OFS + i*K ticks.
  for (genvar i = 0; i < NT; i++) begin : g_tap
    localparam logic [XW-1:0] TAP_V = XW'(OFS + i * K);
    assign hit[i] = (t_i >= TAP_V);
  end

  // Thermometer count of taps passed beyond the first one.
  always_comb begin
    code_o = '0;
    for (int j = 1; j < NT; j++) begin
      if (hit[j]) code_o = code_o + CW'(1);
    end
    below_o  = ~hit[0];
    origin_o = XW'(OFS) + XW'(code_o) * XW'(K);
  end

endmodule

// File: rtl/tcr_fine.sv
module tcr_fine
  import tcode_rx_pkg::*;
#(
  parameter int FW = 2
) (
  input  logic [XW-1:0] t_i,
  input  logic [XW-1:0] origin_i,
  input  logic          below_i,
  output logic [FW-1:0] code_o
);

  localparam int            FMAX   = (1 << FW) - 1;
  localparam logic [XW-1:0] FMAX_X = XW'(FMAX);

  logic [XW-1:0] resid;

  always_comb begin
    resid = t_i - origin_i;
    if (below_i)             code_o = '0;
    else if (resid > FMAX_X) code_o = FW'(FMAX);
    else                     code_o = resid[FW-1:0];
  end

endmodule

// File: rtl/tcode_rx.sv
module tcode_rx
  import tcode_rx_pkg::*;
#(
  parameter int CW       = 2,
  parameter int FW       = 2,
  parameter int K        = 4,
  parameter int RISE_OFS = 4,
  parameter int FALL_OFS = 24,
  parameter int WINDOW   = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_i,
  output logic          valid_o,
  output logic          err_o,
  output logic [CW-1:0] a_o,
  output logic [FW-1:0] b_o,
  output logic [CW-1:0] c_o,
  output logic [FW-1:0] d_o
);

  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam int NCONV = 2;

  // Reset: asserted at once, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic             ref_rise, dat_rise, dat_fall;
  logic             close, good, busy;
  logic [CNT_W-1:0] cnt, rise_t, fall_t;

  tcr_split i_split (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .line_i     (line_i),
    .resync_i   (close),
    .ref_rise_o (ref_rise),
    .dat_rise_o (dat_rise),
    .dat_fall_o (dat_fall)
  );

  tcr_timer #(.WINDOW(WINDOW)) i_timer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ref_rise_i (ref_rise),
    .dat_rise_i (dat_rise),
    .dat_fall_i (dat_fall),
    .close_o    (close),
    .good_o     (good),
    .busy_o     (busy),
    .cnt_o      (cnt),
    .rise_t_o   (rise_t),
    .fall_t_o   (fall_t)
  );

  // Two edge converters, each a coarse stage followed by a fine stage.
  logic [XW-1:0] ivl    [NCONV];
  logic [CW-1:0] ccode  [NCONV];
  logic [FW-1:0] fcode  [NCONV];
  logic [XW-1:0] origin [NCONV];
  logic          below  [NCONV];

  assign ivl[0] = XW'(rise_t);
  assign ivl[1] = XW'(fall_t);

  for (genvar e = 0; e < NCONV; e++) begin : g_edge
    localparam int OFS_E = (e == 0) ? RISE_OFS : FALL_OFS;

    tcr_coarse #(.CW(CW), .K(K), .OFS(OFS_E)) i_coarse (
      .t_i      (ivl[e]),
      .code_o   (ccode[e]),
      .origin_o (origin[e]),
      .below_o  (below[e])
    );

    tcr_fine #(.FW(FW)) i_fine (
      .t_i      (ivl[e]),
      .origin_i (origin[e]),
      .below_i  (below[e]),
      .code_o   (fcode[e])
    );
  end

  // Result stage.
  logic          load;
  logic          valid_d, err_d;
  logic [CW-1:0] a_d, c_d;
  logic [FW-1:0] b_d, d_d;

  always_comb begin
    load    = close & good;
    valid_d = load;
    err_d   = close & ~good;
    a_d     = load ? ccode[0] : a_o;
    b_d     = load ? fcode[0] : b_o;
    c_d     = load ? ccode[1] : c_o;
    d_d     = load ? fcode[1] : d_o;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      a_o     <= '0;
      b_o     <= '0;
      c_o     <= '0;
      d_o     <= '0;
    end else begin
      valid_o <= valid_d;
      err_o   <= err_d;
      a_o     <= a_d;
      b_o     <= b_d;
      c_o     <= c_d;
      d_o     <= d_d;
    end
  end

endmodule

// File: rtl/tcode_rx_chk.sv
module tcode_rx_chk #(
  parameter int CW     = 2,
  parameter int FW     = 2,
  parameter int WINDOW = 40,
  parameter int CNT_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid_o,
  input logic             err_o,
  input logic [CW-1:0]    a_o,
  input logic [FW-1:0]    b_o,
  input logic [CW-1:0]    c_o,
  input logic [FW-1:0]    d_o,
  input logic             ref_rise,
  input logic             dat_rise,
  input logic             busy,
  input logic [CNT_W-1:0] cnt
);

  // R7: a symbol ends either recovered or in error, never both.
  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && err_o));

  // R6: a result strobe lasts a single cycle.
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o || err_o) |=> !(valid_o || err_o));

  // R6: codes move only together with the valid strobe.
  a_r6_codes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({a_o, b_o, c_o, d_o}) |-> valid_o);

  // R2: one rising edge belongs to exactly one path.
  a_r2_path_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_rise && dat_rise));

  // R3: an open symbol's count stays inside 1..WINDOW.
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != '0) && (cnt <= CNT_W'(WINDOW)));

endmodule

bind tcode_rx tcode_rx_chk #(
  .CW     (CW),
  .FW     (FW),
  .WINDOW (WINDOW),
  .CNT_W  (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .valid_o  (valid_o),
  .err_o    (err_o),
  .a_o      (a_o),
  .b_o      (b_o),
  .c_o      (c_o),
  .d_o      (d_o),
  .ref_rise (ref_rise),
  .dat_rise (dat_rise),
  .busy     (busy),
  .cnt      (cnt)
);

// File: tb/test_tcode_rx.sv
`timescale 1ns/1ps
module test_tcode_rx;

  localparam int CW = 2, FW = 2, K = 4, RO = 4, FO = 24, W = 40;
  localparam int CMAX = (1 << CW) - 1;
  localparam int FMAX = (1 << FW) - 1;
  localparam int QD = 16;

  // Columns: ref pulse width, data rise tick (0 = no data pulse), data width, symbol length.
  localparam int NV = 10;
  localparam int VEC [NV][4] = '{
    '{2,  4, 20, 44},   // all codes zero
    '{2, 19, 18, 44},   // top fine and coarse
    '{1,  9, 21, 42},   // mid codes
    '{2,  3, 20, 44},   // intervals below offset
    '{3, 22, 17, 44},   // coarse and fine saturation on rise
    '{2,  6, 44, 53},   // fall missing -> error
    '{2,  0,  0, 44},   // no data pulse -> error, selector left on data
    '{2, 14, 13, 40},   // re-alignment, length == window
    '{2, 10, 25, 40},   // tight pair, next reference in closing tick
    '{3,  5, 30, 44}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic line;
  logic valid_o, err_o;
  logic [CW-1:0] a_o, c_o;
  logic [FW-1:0] b_o, d_o;

  always #2 clk = ~clk;

  tcode_rx #(.CW(CW), .FW(FW), .K(K), .RISE_OFS(RO), .FALL_OFS(FO), .WINDOW(W)) i_tcode_rx (
    .clk(clk), .rst_n(rst_n), .line_i(line),
    .valid_o(valid_o), .err_o(err_o), .a_o(a_o), .b_o(b_o), .c_o(c_o), .d_o(d_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  // Pending results, in the order their symbols were sent.
  int    q_exp [QD];
  bit    q_err [QD];
  int    q_a [QD], q_b [QD], q_c [QD], q_d [QD];
  string q_tag [QD];
  int    qh = 0, qt = 0;
  int    last_a = 0, last_b = 0, last_c = 0, last_d = 0;

  task automatic fail_msg(string req, string what, int act, int exp);
    n_bad++;
    $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
  endtask

  function automatic void model(int t, int ofs, output int cc, output int ff);
    int dd;
    dd = t - ofs;
    if (dd < 0) begin
      cc = 0; ff = 0;
    end else begin
      cc = dd / K;
      if (cc > CMAX) cc = CMAX;
      ff = dd - cc * K;
      if (ff > FMAX) ff = FMAX;
    end
  endfunction

  task automatic tick(bit v);
    @(negedge clk);
    line = v;
  endtask

  task automatic send_symbol(int rw, int tr, int tw, int len, string tag);
    int ea, eb, ec, ed;
    bit ee;
    ee = (tr == 0) || (tr >= W) || (tr + tw >= W);
    model(tr, RO, ea, eb);
    model(tr + tw, FO, ec, ed);
    for (int k = 0; k < len; k++) begin
      bit v;
      v = (k < rw) || (tr != 0 && k >= tr && k < tr + tw);
      tick(v);
      if (k == 0) begin
        q_exp[qt] = cyc + W + 1;
        q_err[qt] = ee;
        q_a[qt] = ea; q_b[qt] = eb; q_c[qt] = ec; q_d[qt] = ed;
        q_tag[qt] = ee ? {tag, " R7"} : tag;
        qt = (qt + 1) % QD;
      end
    end
  endtask

  // Result monitor: checks each strobe at its exact due cycle (R6).
  always @(negedge clk) begin
    if (mon_on && !done) begin
      if (qh != qt && cyc == q_exp[qh]) begin
        n_chk++;
        if (q_err[qh]) begin
          if (!(err_o && !valid_o))
            fail_msg(q_tag[qh], "err strobe (R7)", {valid_o, err_o}, 1);
          n_chk++;
          if (a_o != last_a || b_o != last_b || c_o != last_c || d_o != last_d)
            fail_msg(q_tag[qh], "codes held on error (R7)", {a_o, b_o, c_o, d_o},
                     (last_a << 6) | (last_b << 4) | (last_c << 2) | last_d);
        end else begin
          if (!(valid_o && !err_o))
            fail_msg(q_tag[qh], "valid strobe at fixed latency (R6)", {valid_o, err_o}, 2);
          n_chk++;
          if (a_o != q_a[qh] || b_o != q_b[qh] || c_o != q_c[qh] || d_o != q_d[qh])
            fail_msg(q_tag[qh], "codes A,B,C,D (R4 R5)", {a_o, b_o, c_o, d_o},
                     (q_a[qh] << 6) | (q_b[qh] << 4) | (q_c[qh] << 2) | q_d[qh]);
          last_a = q_a[qh]; last_b = q_b[qh]; last_c = q_c[qh]; last_d = q_d[qh];
        end
        qh = (qh + 1) % QD;
      end else if (valid_o || err_o) begin
        n_chk++;
        fail_msg("R6", "strobe outside due cycle", {valid_o, err_o}, 0);
      end
    end
  end

  task automatic check_idle(string req);
    n_chk++;
    if (valid_o || err_o || a_o != 0 || b_o != 0 || c_o != 0 || d_o != 0)
      fail_msg(req, "idle outputs", {valid_o, err_o, a_o, b_o, c_o, d_o}, 0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    line  = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (4) tick(1'b0);
    check_idle("R1 after release");
    mon_on = 1'b1;

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R9.
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = (i == 7) ? "R8 R2" : (i == 8) ? "R9 R3" : $sformatf("R4 R5 vec%0d", i);
      send_symbol(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], tag);
    end

    // Random codes through the transmitter timing rule; some symbols are back to back (R9).
    for (int n = 0; n < 40; n++) begin
      int ra, rb, rc, rd, tr, tf, rw, len;
      ra = $urandom % (CMAX + 1); rb = $urandom % (FMAX + 1);
      rc = $urandom % (CMAX + 1); rd = $urandom % (FMAX + 1);
      tr = RO + ra * K + rb;
      tf = FO + rc * K + rd;
      rw = 1 + $urandom % 3;
      len = W + $urandom % 4;
      send_symbol(rw, tr, tf - tr, len, "R4 R5 R9 random");
    end

    // Known non-zero result, then reset in the middle of a symbol (R1).
    send_symbol(2, 19, 18, 44, "R5");
    repeat (W + 4) tick(1'b0);
    for (int k = 0; k < 25; k++) tick((k < 2) || (k >= 9));
    tick(1'b0);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    mon_on = 1'b0;
    qh = qt;
    last_a = 0; last_b = 0; last_c = 0; last_d = 0;
    repeat (2) @(negedge clk);
    check_idle("R1 reset mid-symbol");
    rst_n = 1'b1;
    repeat (4) tick(1'b0);
    check_idle("R1 after second release");
    mon_on = 1'b1;
    send_symbol(2, 13, 17, 44, "R2 after reset");
    repeat (W + 4) tick(1'b0);

    n_chk++;
    if (qh != qt) fail_msg("R6", "results left undelivered", (qt - qh + QD) % QD, 0);
    finish_run();
  end

endmodule